// File: doc/BRIEF.md
# Column-Steered Token Ring Arbiter

This block decides which of sixteen tiles may drive a single shared broadcast channel. The tiles form four columns of four. One token moves through them, and only the tile that holds the token is granted the channel. The token moves down one column a tile at a time. When it leaves the last tile of that column, it goes back to the head of the next column. The columns are taken in the cyclic order 0, 1, 2, 3, 0.

Alongside the grants, the block drives a one-hot column-enable vector. This vector switches source power to the column that holds the token and leaves the other three unpowered.

A tile asks for the channel by holding its request line high. When the token reaches a requesting tile, that tile keeps the grant until one of two things happens: it drops its request, or it has held the grant for a programmable number of cycles. The token then moves on. A tile that is not requesting costs one cycle of token travel. Every change of column adds one silent cycle, in which the power enable moves and no grant is given.

Top module: `column_token_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: A tile's grant bit is high only if that tile's request was high at the previous clock edge.
- R3: Tile number t belongs to column t/4 at position t%4. Inside a column, the token visits positions 0, 1, 2, 3 in that order.
- R4: `col_en` is one-hot in every cycle, with bit c high when the token is in column c. Any granted tile lies in the enabled column.
- R5: The token spends exactly one cycle at a tile whose request is low, with `grant` all zero, and then moves to the next position.
- R6: After the token leaves position 3, it spends one transfer cycle and then arrives at position 0 of the next column. The columns are taken in the order 0, 1, 2, 3, 0.
- R7: In the transfer cycle, `col_en` already shows the new column and `grant` is all zero.
- R8: The token spends one cycle at a requesting tile. The tile is then granted for max(`max_hold`, 1) consecutive cycles while its request stays high.
- R9: If a granted tile's request is low at a clock edge, its grant is low from that edge on. The token then moves to the next position.
- R10: After reset, `grant` is all zero, `col_en` is 4'b0001, and the token is at tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | One request line per tile; bit t belongs to tile t |
| max_hold | input | 4 | Grant length limit in cycles; 0 acts as 1 |
| grant | output | 16 | One-hot or zero channel grant, bit t for tile t |
| col_en | output | 4 | One-hot column power enable |

## Verification
The embedded assertions check several properties on every cycle:
- the exclusivity of `grant`;
- the one-hot form of `col_en`, and that any grant lies inside the enabled column;
- that no grant is given without a prior request;
- the silent transfer cycle and the column order;
- the one-cycle pass at idle tiles;
- the release after a request drops;
- the bound on the hold counter.

Some behaviour can only be shown by the bench scenarios:
- the exact token schedule, from the reset position onward;
- the grant length for a given `max_hold`, including zero;
- the full visit order over whole rotations for each request pattern.

The bench sweeps several request patterns against several hold limits and predicts every cycle from the schedule arithmetic.

// File: rtl/cta_pkg.sv
// Package: shared types for the column-steered token arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package cta_pkg;

    // Where the token is in its cycle of visits.
    typedef enum logic [1:0] {
        PH_VISIT = 2'd0,  // token sits at a tile and looks at its request
        PH_HOLD  = 2'd1,  // token held, tile granted
        PH_SHIFT = 2'd2   // token returning; power moves to next column
    } phase_e;

endpackage

// File: rtl/cta_token_walker.sv
// Module: token position and phase sequencer.
// Walks the token through the positions of a column. When the last position is done,
// it spends one shift cycle and enters the next column at position 0.
// Assumes: req_here is the request of the tile at (col_o, pos_o).
// Assumes: hold_done is only meaningful in PH_HOLD.
module cta_token_walker
    import cta_pkg::*;
#(
    parameter int NUM_COLS      = 4,
    parameter int TILES_PER_COL = 4,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int POS_W = (TILES_PER_COL > 1) ? $clog2(TILES_PER_COL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_here,
    input  logic             hold_done,
    output phase_e           phase_o,
    output logic [COL_W-1:0] col_o,
    output logic [POS_W-1:0] pos_o
);

    phase_e           ph_q, ph_d;
    logic [COL_W-1:0] col_q, col_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             step;
    logic             last_pos;
    logic             last_col;

    assign last_pos = (pos_q == POS_W'(TILES_PER_COL - 1));
    assign last_col = (col_q == COL_W'(NUM_COLS - 1));

    // Decide whether the token leaves the current tile this cycle.
    always_comb begin
        step = 1'b0;
        if (ph_q == PH_VISIT) begin
            step = !req_here;
        end else if (ph_q == PH_HOLD) begin
            step = !req_here || hold_done;
        end
    end

    // Compute the next phase and token position.
    always_comb begin
        ph_d  = ph_q;
        col_d = col_q;
        pos_d = pos_q;
        unique case (ph_q)
            PH_VISIT: if (req_here) ph_d = PH_HOLD;
            PH_SHIFT: ph_d = PH_VISIT;
            default:  ph_d = ph_q;
        endcase
        if (step) begin
            if (last_pos) begin
                ph_d  = PH_SHIFT;
                pos_d = '0;
                col_d = last_col ? '0 : col_q + COL_W'(1);
            end else begin
                ph_d  = PH_VISIT;
                pos_d = pos_q + POS_W'(1);
            end
        end
    end

    // Register token state; reset places it at tile 0 of column 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_VISIT;
            col_q <= '0;
            pos_q <= '0;
        end else begin
            ph_q  <= ph_d;
            col_q <= col_d;
            pos_q <= pos_d;
        end
    end

    assign phase_o = ph_q;
    assign col_o   = col_q;
    assign pos_o   = pos_q;

    AST_SHIFT_TO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SHIFT) |=> (ph_q == PH_VISIT && pos_q == '0)); // R6

    AST_COL_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_SHIFT) |-> (col_q == (($past(col_q) == COL_W'(NUM_COLS - 1)) ? COL_W'(0) : $past(col_q) + COL_W'(1)))); // R6

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_VISIT && !req_here && !last_pos) |=> (ph_q == PH_VISIT && pos_q == $past(pos_q) + POS_W'(1))); // R5

endmodule

// File: rtl/cta_hold_timer.sv
// Module: grant-length counter.
// Counts the cycles of the current grant and signals when the limit is reached.
// A limit of zero behaves as one.
// Assumes: limit is stable while a grant is active.
module cta_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              active,
    input  logic [HOLD_W-1:0] limit,
    output logic              done
);

    logic [HOLD_W-1:0] cnt_q;

    assign done = active && (cnt_q >= limit);

    // Load 1 when a grant begins; count up while the grant runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= HOLD_W'(1);
        end else if (active && !done) begin
            cnt_q <= cnt_q + HOLD_W'(1);
        end
    end

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q != '0 && (cnt_q <= limit || cnt_q == HOLD_W'(1)))); // R8

endmodule

// File: rtl/cta_grant_decode.sv
// Module: turns the token position into per-tile grants and per-column power enables.
// Assumes: tile index = column * TILES_PER_COL + position.
module cta_grant_decode #(
    parameter int NUM_COLS      = 4,
    parameter int TILES_PER_COL = 4,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int POS_W = (TILES_PER_COL > 1) ? $clog2(TILES_PER_COL) : 1,
    localparam int NUM_TILES = NUM_COLS * TILES_PER_COL
) (
    input  logic                 hold_i,
    input  logic [COL_W-1:0]     col_i,
    input  logic [POS_W-1:0]     pos_i,
    output logic [NUM_TILES-1:0] grant_o,
    output logic [NUM_COLS-1:0]  col_en_o
);

    // One enable per column, and one grant per tile inside that column.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign col_en_o[c] = (col_i == COL_W'(c));
        for (genvar p = 0; p < TILES_PER_COL; p++) begin : g_tile
            assign grant_o[c*TILES_PER_COL+p] = hold_i && (col_i == COL_W'(c)) && (pos_i == POS_W'(p));
        end
    end

endmodule

// File: rtl/column_token_arbiter.sv
// Module: top of the column-steered token arbiter.
// A single token gives one tile at a time access to a shared broadcast channel.
// Power is steered to the column that holds the token.
// Assumes: req is synchronous to clk, and max_hold is static during a grant.
module column_token_arbiter
    import cta_pkg::*;
#(
    parameter int NUM_COLS      = 4,
    parameter int TILES_PER_COL = 4,
    parameter int HOLD_W        = 4,
    localparam int NUM_TILES = NUM_COLS * TILES_PER_COL,
    localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int POS_W = (TILES_PER_COL > 1) ? $clog2(TILES_PER_COL) : 1,
    localparam int IDX_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TILES-1:0] req,
    input  logic [HOLD_W-1:0]    max_hold,
    output logic [NUM_TILES-1:0] grant,
    output logic [NUM_COLS-1:0]  col_en
);

    phase_e           phase;
    logic [COL_W-1:0] col;
    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] tile_idx;
    logic             req_here;
    logic             hold_done;
    logic             hold_start;
    logic             hold_active;

    // Find the token's tile and the request at that tile.
    assign tile_idx    = IDX_W'(col) * IDX_W'(TILES_PER_COL) + IDX_W'(pos);
    assign req_here    = req[tile_idx];
    assign hold_start  = (phase == PH_VISIT) && req_here;
    assign hold_active = (phase == PH_HOLD);

    cta_token_walker #(
        .NUM_COLS      (NUM_COLS),
        .TILES_PER_COL (TILES_PER_COL)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_here  (req_here),
        .hold_done (hold_done),
        .phase_o   (phase),
        .col_o     (col),
        .pos_o     (pos)
    );

    cta_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (hold_start),
        .active (hold_active),
        .limit  (max_hold),
        .done   (hold_done)
    );

    cta_grant_decode #(
        .NUM_COLS      (NUM_COLS),
        .TILES_PER_COL (TILES_PER_COL)
    ) u_decode (
        .hold_i   (hold_active),
        .col_i    (col),
        .pos_i    (pos),
        .grant_o  (grant),
        .col_en_o (col_en)
    );

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R1

    AST_COLEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(col_en)); // R4

    AST_SHIFT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT) |-> (grant == '0)); // R7

    AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && !req_here) |=> (grant == '0)); // R9

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_chk
        AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> $past(req[t])); // R2
        AST_GRANT_IN_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> col_en[t / TILES_PER_COL]); // R4
    end

endmodule

// File: tb/column_token_arbiter_tb.sv
module column_token_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int TP = 4;
    localparam int NT = NC * TP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] req = '0;
    logic [3:0]    max_hold = 4'd1;
    logic [NT-1:0] grant;
    logic [NC-1:0] col_en;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    column_token_arbiter u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .max_hold (max_hold),
        .grant    (grant),
        .col_en   (col_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
            summary();
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Predict every cycle of some whole rotations for a fixed request pattern.
    task automatic run_schedule(logic [NT-1:0] pat, logic [3:0] h, int rounds);
        int eff;
        req = pat;
        max_hold = h;
        eff = (h == 0) ? 1 : int'(h);
        do_reset();
        check("R10 grant after reset", 32'(grant), 32'd0);
        check("R10 col_en after reset", 32'(col_en), 32'd1);
        for (int r = 0; r < rounds; r++) begin
            for (int c = 0; c < NC; c++) begin
                for (int p = 0; p < TP; p++) begin
                    int tile = c * TP + p;
                    // R3 R5: visit cycle at this tile, no grant yet
                    check("R5 visit grant", 32'(grant), 32'd0);
                    check("R4 visit col_en", 32'(col_en), 32'(1) << c);
                    @(negedge clk);
                    if (pat[tile]) begin
                        for (int k = 0; k < eff; k++) begin
                            check("R8 hold grant", 32'(grant), 32'(1) << tile);
                            check("R4 hold col_en", 32'(col_en), 32'(1) << c);
                            @(negedge clk);
                        end
                    end
                end
                // R6 R7: transfer cycle to next column
                check("R7 shift grant", 32'(grant), 32'd0);
                check("R6 shift col_en", 32'(col_en), 32'(1) << ((c + 1) % NC));
                @(negedge clk);
            end
        end
    endtask

    initial begin
        logic [NT-1:0] pats [6];
        logic [3:0]    holds [3];
        bit            seen;
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8421;
        pats[3] = 16'hA5A5; pats[4] = 16'h0001; pats[5] = 16'h8000;
        holds[0] = 4'd0; holds[1] = 4'd1; holds[2] = 4'd3;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 3; j++) begin
                run_schedule(pats[i], holds[j], 2);
            end
        end
        run_schedule(16'h1248, 4'd15, 1);

        // R9: a request dropped during the grant releases the channel at once.
        req = 16'h0020;
        max_hold = 4'd7;
        do_reset();
        seen = 1'b0;
        for (int w = 0; w < 40 && !seen; w++) begin
            if (grant[5]) seen = 1'b1;
            else @(negedge clk);
        end
        check("R9 grant reached tile 5", 32'(seen), 32'd1);
        @(negedge clk);
        check("R9 still granted", 32'(grant), 32'h20);
        req = '0;
        @(negedge clk);
        check("R9 released after drop", 32'(grant), 32'd0);
        check("R9 column kept", 32'(col_en), 32'd2);
        @(negedge clk);
        check("R9 token moved on", 32'(grant), 32'd0);
        check("R4 column after drop", 32'(col_en), 32'd2);

        summary();
    end

endmodule